// File: doc/BRIEF.md
# Dual-Timing FIFO with Programmable Fill Flags

This block is a single-clock synchronous FIFO. By default it holds 256 words of 36 bits. At master reset a configuration pin selects one of two output styles. In standard timing, a read strobe moves the oldest word into the output register, and the two status outputs mean "empty" and "full". In fall-through timing, the oldest word is placed on the output without any strobe. The status outputs then mean "output ready" and "input ready", and a read strobe consumes the word being presented.

Two threshold flags warn that the buffer is nearly drained or nearly filled. Each one is compared against its own 8-bit offset. At master reset a two-bit select picks a preset value for both offsets. Software-free logic around the FIFO can later replace the offsets in two ways: in one cycle over the write data bus, or one bit per clock through a serial bit and its enable. A partial reset throws away the stored words but keeps the timing style and both offsets. A master reset also reloads them.

Top module: `dtfifo_top`

## Requirements
- R1: Words leave in the order they were written, and up to DEPTH (default 256) words of WIDTH (default 36) bits are held. A write and a read on the same edge are both accepted, as long as the FIFO is not full (for the write) and not empty (for the read) before that edge.
- R2: In standard timing, rdFlag is 1 exactly when no word is stored and wrFlag is 1 exactly when DEPTH words are stored. An accepted read loads the oldest word into rdData after that edge, and rdData holds its value otherwise.
- R3: A write while the storage array is full and a read while it is empty are ignored: no pointer or count changes, and in standard timing rdData keeps its value.
- R4: In fall-through timing, a word written into an empty FIFO is on rdData, with rdFlag (output ready) at 1, right after the edge that accepts it, with no read strobe. A read strobe while rdFlag is 1 consumes that word, and the next word (if any) is presented after the same edge. wrFlag (input ready) is 1 while the storage array is not full. A read strobe while rdFlag is 0 has no effect.
- R5: Occupancy is the number of words in the storage array, plus the presented word in fall-through timing. aeFlag is 1 when the occupancy is at or below the almost-empty offset. afFlag is 1 when DEPTH minus the words in the storage array is at or below the almost-full offset.
- R6: Master reset (masterRst, synchronous, highest priority) empties the FIFO and clears rdData to 0. It latches the timing style from cfgFwft (1 = fall-through). It sets both offsets from cfgOffSel: 00 gives 8, 01 gives 16, 10 or 11 gives 64.
- R7: While progLoad is 1 (and no reset is active), the almost-empty offset takes wrData[7:0] and the almost-full offset takes wrData[15:8] at the edge. No write is accepted in that cycle.
- R8: On each edge with serEn at 1 (and progLoad at 0, no reset), the 16-bit value {almost-empty offset, almost-full offset} shifts left by one and serBit enters at bit 0. Sixteen enabled bits therefore load the almost-empty offset first, then the almost-full offset, each most significant bit first.
- R9: Partial reset (partialRst, synchronous) empties the FIFO and clears rdData to 0. It keeps the timing style and both offsets. If both resets are active, master reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| masterRst | input | 1 | Synchronous master reset, reloads configuration |
| partialRst | input | 1 | Synchronous partial reset, keeps configuration |
| cfgFwft | input | 1 | Timing style sampled during master reset (1 = fall-through) |
| cfgOffSel | input | 2 | Preset offset select sampled during master reset |
| wrEn | input | 1 | Write strobe |
| wrData | input | WIDTH | Write data; also the parallel offset source |
| rdEn | input | 1 | Read strobe |
| rdData | output | WIDTH | Output register |
| progLoad | input | 1 | Parallel offset load strobe |
| serEn | input | 1 | Serial offset load enable |
| serBit | input | 1 | Serial offset data bit |
| rdFlag | output | 1 | Empty (standard) or output ready (fall-through) |
| wrFlag | output | 1 | Full (standard) or input ready (fall-through) |
| aeFlag | output | 1 | Almost-empty flag |
| afFlag | output | 1 | Almost-full flag |

## Verification
The bench uses the default parameters, 36 bits by 256 words with 8-bit offsets. At that size the storage array can be filled completely in a few hundred cycles, so writes at full and the 64-word preset are both reachable. The bench runs each of the three preset selects and both timing styles. It also loads small offsets in parallel and serially, which moves both threshold edges close to empty and close to full.

// File: rtl/dtfifo_pkg.sv
package dtfifo_pkg;
  // strobes from control to datapath, one cycle
  typedef struct packed {
    logic memWr;      // store wrData at wrAddr
    logic outFromMem; // load output register from rdAddr
    logic outFromIn;  // load output register straight from wrData
    logic outClr;     // clear output register
  } dp_strobe_t;
endpackage

// File: rtl/dtfifo_ctrl.sv
module dtfifo_ctrl
  import dtfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int OFFW  = AW
) (
  input  logic            clk,
  input  logic            masterRst,
  input  logic            partialRst,
  input  logic            cfgFwft,
  input  logic [1:0]      cfgOffSel,
  input  logic            wrEn,
  input  logic            rdEn,
  input  logic            progLoad,
  input  logic [2*OFFW-1:0] progWord,
  input  logic            serEn,
  input  logic            serBit,
  output dp_strobe_t      strobe,
  output logic [AW-1:0]   wrAddr,
  output logic [AW-1:0]   rdAddr,
  output logic            rdFlag,
  output logic            wrFlag,
  output logic            aeFlag,
  output logic            afFlag,
  output logic            modeFwft,
  output logic [OFFW-1:0] aeOff,
  output logic [OFFW-1:0] afOff,
  output logic [CW-1:0]   memCount
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic outValid;
  logic memFull, memEmpty, wrAcc, take, popMem, bypass, memWr, anyRst;
  logic [CW:0] occupancy;
  logic [CW-1:0] freeSlots;

  function automatic logic [OFFW-1:0] presetOff(input logic [1:0] sel);
    case (sel)
      2'b00:   presetOff = OFFW'(8);
      2'b01:   presetOff = OFFW'(16);
      default: presetOff = OFFW'(64);
    endcase
  endfunction

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    nextPtr = (p == LAST_PTR) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    anyRst   = masterRst | partialRst;
    memFull  = (memCount == FULL_CNT);
    memEmpty = (memCount == '0);
    wrAcc    = wrEn & ~memFull & ~progLoad & ~anyRst;
    if (modeFwft) begin
      take   = ~outValid | rdEn;
      popMem = take & ~memEmpty & ~anyRst;
      bypass = take & memEmpty & wrAcc;
    end else begin
      take   = 1'b0;
      popMem = rdEn & ~memEmpty & ~anyRst;
      bypass = 1'b0;
    end
    memWr = wrAcc & ~bypass;
    strobe.memWr      = memWr;
    strobe.outFromMem = popMem;
    strobe.outFromIn  = bypass;
    strobe.outClr     = anyRst;
  end

  always_ff @(posedge clk) begin
    if (anyRst) begin
      wrAddr   <= '0;
      rdAddr   <= '0;
      memCount <= '0;
      outValid <= 1'b0;
    end else begin
      if (memWr)  wrAddr <= nextPtr(wrAddr);
      if (popMem) rdAddr <= nextPtr(rdAddr);
      memCount <= memCount + CW'(memWr) - CW'(popMem);
      if (modeFwft && take) outValid <= popMem | bypass;
    end
  end

  // configuration: only master reset reloads it
  always_ff @(posedge clk) begin
    if (masterRst) begin
      modeFwft <= cfgFwft;
      aeOff    <= presetOff(cfgOffSel);
      afOff    <= presetOff(cfgOffSel);
    end else if (!partialRst) begin
      if (progLoad) begin
        aeOff <= progWord[OFFW-1:0];
        afOff <= progWord[2*OFFW-1:OFFW];
      end else if (serEn) begin
        {aeOff, afOff} <= {aeOff[OFFW-2:0], afOff, serBit};
      end
    end
  end

  always_comb begin
    occupancy = {1'b0, memCount} + (CW+1)'(modeFwft & outValid);
    freeSlots = FULL_CNT - memCount;
    aeFlag    = occupancy <= (CW+1)'(aeOff);
    afFlag    = {1'b0, freeSlots} <= (CW+1)'(afOff);
    rdFlag    = modeFwft ? outValid : memEmpty;
    wrFlag    = modeFwft ? ~memFull : memFull;
  end
endmodule

// File: rtl/dtfifo_dpath.sv
module dtfifo_dpath
  import dtfifo_pkg::*;
#(
  parameter int WIDTH = 36,
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  dp_strobe_t       strobe,
  input  logic [AW-1:0]    wrAddr,
  input  logic [AW-1:0]    rdAddr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData
);
  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.memWr) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (strobe.outClr)          rdData <= '0;
    else if (strobe.outFromMem) rdData <= store[rdAddr];
    else if (strobe.outFromIn)  rdData <= wrData;
  end
endmodule

// File: rtl/dtfifo_top.sv
module dtfifo_top
  import dtfifo_pkg::*;
#(
  parameter int WIDTH = 36,
  parameter int DEPTH = 256
) (
  input  logic             clk,
  input  logic             masterRst,
  input  logic             partialRst,
  input  logic             cfgFwft,
  input  logic [1:0]       cfgOffSel,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  input  logic             progLoad,
  input  logic             serEn,
  input  logic             serBit,
  output logic             rdFlag,
  output logic             wrFlag,
  output logic             aeFlag,
  output logic             afFlag
);
  localparam int AW   = $clog2(DEPTH);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int OFFW = AW;

  dp_strobe_t        strobe;
  logic [AW-1:0]     wrAddr, rdAddr;
  logic              modeFwft;
  logic [OFFW-1:0]   aeOff, afOff;
  logic [CW-1:0]     memCount;

  dtfifo_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .OFFW(OFFW)) u_ctrl (
    .clk(clk), .masterRst(masterRst), .partialRst(partialRst),
    .cfgFwft(cfgFwft), .cfgOffSel(cfgOffSel),
    .wrEn(wrEn), .rdEn(rdEn), .progLoad(progLoad),
    .progWord(wrData[2*OFFW-1:0]), .serEn(serEn), .serBit(serBit),
    .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .rdFlag(rdFlag), .wrFlag(wrFlag), .aeFlag(aeFlag), .afFlag(afFlag),
    .modeFwft(modeFwft), .aeOff(aeOff), .afOff(afOff), .memCount(memCount)
  );

  dtfifo_dpath #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_dpath (
    .clk(clk), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/dtfifo_checker.sv
module dtfifo_checker #(
  parameter int WIDTH = 36,
  parameter int DEPTH = 256,
  parameter int CW    = 9,
  parameter int OFFW  = 8
) (
  input logic             clk,
  input logic             masterRst,
  input logic             partialRst,
  input logic             wrEn,
  input logic             rdEn,
  input logic             progLoad,
  input logic [WIDTH-1:0] wrData,
  input logic [WIDTH-1:0] rdData,
  input logic             rdFlag,
  input logic             wrFlag,
  input logic             modeFwft,
  input logic [OFFW-1:0]  aeOff,
  input logic [OFFW-1:0]  afOff,
  input logic [CW-1:0]    memCount
);
  logic seenRst = 1'b0;
  always_ff @(posedge clk) seenRst <= seenRst | masterRst;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!seenRst)
    memCount <= CW'(DEPTH)); // R1

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!seenRst || masterRst || partialRst)
    (!modeFwft && wrFlag && wrEn && !rdEn && !progLoad)
    |=> (wrFlag && memCount == $past(memCount))); // R3

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!seenRst || masterRst || partialRst)
    (!modeFwft && rdFlag && rdEn && !wrEn)
    |=> ($stable(rdData) && rdFlag)); // R3

  AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!seenRst || masterRst || partialRst)
    (modeFwft && !rdFlag && memCount == '0 && wrEn && !progLoad)
    |=> (rdFlag && rdData == $past(wrData))); // R4

  AST_MRST_CLEARS: assert property (@(posedge clk) disable iff (!seenRst)
    masterRst |=> (memCount == '0 && rdData == '0 && (modeFwft ? !rdFlag : rdFlag))); // R6

  AST_PAR_LOAD: assert property (@(posedge clk) disable iff (!seenRst)
    (progLoad && !masterRst && !partialRst)
    |=> (aeOff == $past(wrData[OFFW-1:0]) && afOff == $past(wrData[2*OFFW-1:OFFW]))); // R7

  AST_PRST_KEEPS: assert property (@(posedge clk) disable iff (!seenRst)
    (partialRst && !masterRst)
    |=> ($stable(modeFwft) && $stable(aeOff) && $stable(afOff) && memCount == '0)); // R9
endmodule

bind dtfifo_top dtfifo_checker #(
  .WIDTH(WIDTH), .DEPTH(DEPTH), .CW(CW), .OFFW(OFFW)
) u_chk (
  .clk(clk), .masterRst(masterRst), .partialRst(partialRst),
  .wrEn(wrEn), .rdEn(rdEn), .progLoad(progLoad), .wrData(wrData),
  .rdData(rdData), .rdFlag(rdFlag), .wrFlag(wrFlag),
  .modeFwft(modeFwft), .aeOff(aeOff), .afOff(afOff), .memCount(memCount)
);

// File: tb/dtfifo_top_tb.sv
module dtfifo_top_tb;
  localparam int WIDTH = 36;
  localparam int DEPTH = 256;

  logic clk = 1'b0;
  logic masterRst = 1'b0, partialRst = 1'b0, cfgFwft = 1'b0;
  logic [1:0] cfgOffSel = 2'b00;
  logic wrEn = 1'b0, rdEn = 1'b0, progLoad = 1'b0, serEn = 1'b0, serBit = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic [WIDTH-1:0] rdData;
  logic rdFlag, wrFlag, aeFlag, afFlag;

  int checks = 0;
  int errors = 0;
  bit armed = 1'b0;

  always #10 clk = ~clk;

  dtfifo_top #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .masterRst(masterRst), .partialRst(partialRst),
    .cfgFwft(cfgFwft), .cfgOffSel(cfgOffSel), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .progLoad(progLoad), .serEn(serEn),
    .serBit(serBit), .rdFlag(rdFlag), .wrFlag(wrFlag), .aeFlag(aeFlag),
    .afFlag(afFlag)
  );

  // behavioural reference
  logic [WIDTH-1:0] q[$];
  bit mFwft = 0, mOutV = 0;
  int mAe = 8, mAf = 8;
  logic [WIDTH-1:0] mRd = '0;

  function automatic int presetOf(input logic [1:0] s);
    return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 64;
  endfunction

  always @(posedge clk) begin
    bit full, wacc;
    logic [15:0] sh;
    if (masterRst) begin
      q.delete(); mOutV = 0; mRd = '0; mFwft = cfgFwft;
      mAe = presetOf(cfgOffSel); mAf = mAe;
    end else if (partialRst) begin
      q.delete(); mOutV = 0; mRd = '0;
    end else begin
      full = (q.size() == DEPTH);
      wacc = wrEn && !full && !progLoad;
      if (mFwft) begin
        if (!mOutV || rdEn) begin
          if (q.size() > 0) begin
            mRd = q.pop_front(); mOutV = 1;
            if (wacc) q.push_back(wrData);
          end else if (wacc) begin
            mRd = wrData; mOutV = 1;
          end else mOutV = 0;
        end else if (wacc) q.push_back(wrData);
      end else begin
        if (rdEn && q.size() > 0) mRd = q.pop_front();
        if (wacc) q.push_back(wrData);
      end
      if (progLoad) begin
        mAe = int'(wrData[7:0]); mAf = int'(wrData[15:8]);
      end else if (serEn) begin
        sh = {mAe[7:0], mAf[7:0]};
        sh = {sh[14:0], serBit};
        mAe = int'(sh[15:8]); mAf = int'(sh[7:0]);
      end
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    int occ;
    bit expRd, expWr;
    if (armed) begin
      occ   = q.size() + ((mFwft && mOutV) ? 1 : 0);
      expRd = mFwft ? mOutV : (q.size() == 0);
      expWr = mFwft ? (q.size() < DEPTH) : (q.size() == DEPTH);
      chk(rdFlag == expRd, "R2 R4 R3 rdFlag", longint'(rdFlag), longint'(expRd));
      chk(wrFlag == expWr, "R2 R4 R3 wrFlag", longint'(wrFlag), longint'(expWr));
      chk(aeFlag == (occ <= mAe), "R5 R7 R8 aeFlag", longint'(aeFlag), longint'(occ <= mAe));
      chk(afFlag == ((DEPTH - q.size()) <= mAf), "R5 R7 R8 afFlag",
          longint'(afFlag), longint'((DEPTH - q.size()) <= mAf));
      if (!mFwft || mOutV)
        chk(rdData == mRd, "R1 R2 R6 R9 rdData", longint'(rdData), longint'(mRd));
    end
  end

  task automatic idle();
    wrEn = 0; rdEn = 0; progLoad = 0; serEn = 0; masterRst = 0; partialRst = 0;
  endtask

  task automatic step(input bit w, input bit r, input logic [WIDTH-1:0] d);
    @(negedge clk);
    idle(); wrEn = w; rdEn = r; wrData = d;
  endtask

  task automatic doMrst(input bit fw, input logic [1:0] sel);
    @(negedge clk);
    idle(); masterRst = 1; cfgFwft = fw; cfgOffSel = sel;
    @(negedge clk);
    masterRst = 0; cfgFwft = ~fw; cfgOffSel = ~sel;
    armed = 1;
  endtask

  task automatic doPrst();
    @(negedge clk);
    idle(); partialRst = 1; cfgFwft = ~mFwft;
    @(negedge clk);
    partialRst = 0;
  endtask

  function automatic logic [WIDTH-1:0] pat(input int i);
    return {i[17:0], ~i[17:0]};
  endfunction

  task automatic mixed(input int n, input int wPct, input int rPct);
    for (int i = 0; i < n; i++)
      step(($urandom % 100) < wPct, ($urandom % 100) < rPct, pat($urandom));
  endtask

  task automatic serialLoad(input logic [7:0] ae, input logic [7:0] af);
    logic [15:0] v;
    v = {ae, af};
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk);
      idle(); serEn = 1; serBit = v[i];
    end
    @(negedge clk); idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R6: standard timing, preset 8
    doMrst(0, 2'b00);
    @(negedge clk);
    chk(rdFlag == 1 && wrFlag == 0 && rdData == '0, "R6 reset state", longint'({rdFlag, wrFlag}), 2);
    // R2 R3: fill past full, then drain past empty
    for (int i = 0; i < DEPTH + 5; i++) step(1, 0, pat(i));
    step(1, 1, pat(999));          // full: write refused, read taken (R1 R3)
    for (int i = 0; i < DEPTH + 5; i++) step(0, 1, '0);
    mixed(400, 60, 50);
    // R7: parallel load ae=3 af=5
    @(negedge clk); idle(); progLoad = 1; wrEn = 1; wrData = 36'h0_0000_0503;
    mixed(300, 70, 30);
    mixed(300, 30, 70);
    // R8: serial load ae=20 af=2
    serialLoad(8'd20, 8'd2);
    mixed(600, 75, 25);
    // R9: partial reset keeps configuration
    doPrst();
    mixed(300, 50, 50);
    // R4: fall-through, preset 16
    doMrst(1, 2'b01);
    step(1, 0, 36'h1_2345_6789);
    step(0, 0, '0);
    chk(rdFlag == 1 && rdData == 36'h1_2345_6789, "R4 fall-through word",
        longint'(rdData), longint'(36'h1_2345_6789));
    step(0, 1, '0);
    step(0, 1, '0);                 // read while not ready: no effect
    for (int i = 0; i < DEPTH + 4; i++) step(1, 0, pat(i + 7));
    for (int i = 0; i < DEPTH + 4; i++) step(($urandom % 2) == 0, 1, pat(i));
    mixed(500, 55, 55);
    doPrst();
    step(1, 0, 36'h0_0000_0077);
    mixed(300, 60, 40);
    // R6: preset 64 in fall-through, then the fourth select
    doMrst(1, 2'b10);
    mixed(500, 60, 40);
    doMrst(0, 2'b11);
    mixed(500, 60, 40);
    step(0, 0, '0);
    step(0, 0, '0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule